// File: doc/BRIEF.md
# Close-Neighbor Speculative Translation Buffer

This block is a fully associative buffer that turns virtual page numbers into physical page numbers for a core's load and store path. A request carries a full virtual address. The low 12 bits form the offset of a 4 KB page and pass through unchanged. When the page number matches a stored tag exactly, the buffer returns the stored translation one cycle after the request is accepted.

When no tag matches exactly, the buffer looks for a resident "neighbour": a valid entry whose upper `NBR_BITS` page-number bits equal those of the request. Physical memory is often allocated contiguously, so the buffer extrapolates a speculative physical page from that neighbour. The speculative page is the neighbour's physical page plus the distance between the two virtual pages. It comes back with the same latency as a hit and is marked speculative. Every response that is not an exact hit also raises a walk request toward an external page walker. Only one walk is in flight at a time, and new requests are held off with a low ready until the walk ends.

When the walker answers, the verified translation is written into a free slot, or into the least recently used slot when none is free. A one-cycle verify pulse then carries the page pair to the consumer, which compares it with the speculation it holds. Speculative answers do not change the table or its recency order.

Top module: `nbr_xlat_buf`

## Requirements
- R1: After synchronous active-low reset the table is empty, `req_ready` is 1, and `rsp_valid`, `walk_req_valid` and `verify_valid` are 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) whose page number equals a valid tag gives, after that edge, a one-cycle response with `rsp_kind` = 2'b01 (hit) and `rsp_paddr` = {stored physical page, request offset}.
- R3: For hit and speculative responses, `rsp_paddr[11:0]` equals the low 12 bits of the accepted request address.
- R4: With no exact match, a valid entry whose top `NBR_BITS` page-number bits equal the request's gives `rsp_kind` = 2'b10 (speculative). The physical page is then neighbour page + (request virtual page − neighbour virtual page), taken modulo 2^PPN_W, so the distance may be negative.
- R5: When several neighbours match, the one in the lowest slot index is used. Free slots are filled lowest index first.
- R6: With neither an exact nor a neighbour match, `rsp_kind` = 2'b00 (miss) and `rsp_paddr` is zero.
- R7: Every miss or speculative response has `walk_req_valid` high in the same cycle, with `walk_req_vpn` equal to the request's page number. A hit raises no walk.
- R8: From the cycle a walk is requested until the cycle after `walk_rsp_valid`, `req_ready` is 0. Requests presented in that time give no response and no walk.
- R9: A walk response installs the translation. In the next cycle `verify_valid` pulses for one cycle with `verify_vpn` and `verify_ppn` equal to the walked pair, and `req_ready` is 1 again.
- R10: With all slots valid, a fill replaces the least recently used entry. Exact hits and fills both count as uses.
- R11: A speculative response does not count as a use of its neighbour, nor of any other entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Buffer can accept a request (no walk in flight) |
| req_vaddr | input | VPN_W+12 | Virtual address of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 00 miss, 01 hit, 10 speculative |
| rsp_paddr | output | PPN_W+12 | Translated or speculative physical address, zero on miss |
| walk_req_valid | output | 1 | One-cycle request to the page walker |
| walk_req_vpn | output | VPN_W | Page number to walk |
| walk_rsp_valid | input | 1 | Walker returns the accurate translation |
| walk_rsp_ppn | input | PPN_W | Accurate physical page |
| verify_valid | output | 1 | One-cycle verify broadcast |
| verify_vpn | output | VPN_W | Verified virtual page |
| verify_ppn | output | PPN_W | Verified physical page |

## Verification
The bench builds the buffer with `ENTRIES` = 4, `VPN_W` = 20, `PPN_W` = 24 and `NBR_BITS` = 12. So neighbours share a 256-page window, and the table fills after four walks. With only four slots, the vector sequence reaches evictions within a dozen requests. Those evictions show the least recently used order, and they show that a speculative answer leaves that order alone. They also give a case where two neighbours extrapolate differently, so picking the wrong one shows up. The wide physical page makes a negative page distance sign-extend on the way, and a page in another window gives a plain miss.

// File: rtl/nbr_xlat_pkg.sv
// Shared types for the close-neighbour translation buffer.
// Assumes 4 KB pages; response kind encoding is visible at the top ports.
package nbr_xlat_pkg;
    localparam int OFS_W = 12;

    typedef enum logic [1:0] {
        KIND_MISS = 2'b00,
        KIND_HIT  = 2'b01,
        KIND_SPEC = 2'b10
    } rsp_kind_e;
endpackage

// File: rtl/nbr_lookup.sv
// Combinational lookup: exact tag match and approximate neighbour match
// on the upper NBR_BITS of the page number, lowest index first, plus the
// extrapolated speculative physical page. Assumes at most one exact match.
module nbr_lookup #(
    parameter int ENTRIES  = 64,
    parameter int VPN_W    = 20,
    parameter int PPN_W    = 24,
    parameter int NBR_BITS = 12,
    parameter int IDX_W    = $clog2(ENTRIES)
) (
    input  logic [VPN_W-1:0]                req_vpn,
    input  logic [ENTRIES-1:0]              valid_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   tags,
    input  logic [ENTRIES-1:0][PPN_W-1:0]   ppns,
    output logic                            exact_hit,
    output logic [IDX_W-1:0]                exact_idx,
    output logic [PPN_W-1:0]                exact_ppn,
    output logic                            nbr_hit,
    output logic [PPN_W-1:0]                spec_ppn
);
    localparam int SUM_W = ((PPN_W > VPN_W) ? PPN_W : VPN_W) + 1;

    logic [ENTRIES-1:0] exact_vec;
    logic [ENTRIES-1:0] nbr_vec;
    logic [IDX_W-1:0]   nbr_idx;
    logic [VPN_W:0]     vdist;
    logic [SUM_W-1:0]   vdist_ext;
    logic [SUM_W-1:0]   base_ext;
    logic [SUM_W-1:0]   sum;

    // Per-entry comparators for exact and upper-bit matches
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign exact_vec[g] = valid_vec[g] && (tags[g] == req_vpn);
        assign nbr_vec[g]   = valid_vec[g] &&
            (tags[g][VPN_W-1 -: NBR_BITS] == req_vpn[VPN_W-1 -: NBR_BITS]);
    end

    // Priority encoders: lowest index wins for both match kinds
    always_comb begin
        exact_hit = 1'b0;
        exact_idx = '0;
        nbr_hit   = 1'b0;
        nbr_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (exact_vec[i] && !exact_hit) begin
                exact_hit = 1'b1;
                exact_idx = IDX_W'(i);
            end
            if (nbr_vec[i] && !nbr_hit) begin
                nbr_hit = 1'b1;
                nbr_idx = IDX_W'(i);
            end
        end
    end

    // Extrapolation: neighbour page plus signed virtual page distance
    always_comb begin
        vdist     = {1'b0, req_vpn} - {1'b0, tags[nbr_idx]};
        vdist_ext = {{(SUM_W-VPN_W-1){vdist[VPN_W]}}, vdist};
        base_ext  = {{(SUM_W-PPN_W){1'b0}}, ppns[nbr_idx]};
        sum       = base_ext + vdist_ext;
        spec_ppn  = sum[PPN_W-1:0];
        exact_ppn = ppns[exact_idx];
    end
endmodule

// File: rtl/nbr_lru.sv
// Least-recently-used tracker built from per-entry age counters that
// always form a permutation of 0..ENTRIES-1. A touch zeroes the touched
// age and ages every younger entry. Victim is the lowest free slot, else
// the oldest slot. Assumes at most one touch per cycle.
module nbr_lru #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic                          free_found;

    // Age update on each use
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Victim choice: lowest free slot first, then the oldest slot
    always_comb begin
        victim_idx = '0;
        free_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec[i] && !free_found) begin
                free_found = 1'b1;
                victim_idx = IDX_W'(i);
            end
        end
        if (!free_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == IDX_W'(ENTRIES-1)) victim_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nbr_xlat_buf.sv
// Top of the close-neighbour speculative translation buffer. Holds the
// tag and page arrays, registers responses one cycle after acceptance,
// issues one walk at a time and installs the walked translation.
// Assumes the walker answers only while a walk is outstanding.
module nbr_xlat_buf #(
    parameter int ENTRIES  = 64,
    parameter int VPN_W    = 20,
    parameter int PPN_W    = 24,
    parameter int NBR_BITS = 12,
    parameter int VA_W     = VPN_W + nbr_xlat_pkg::OFS_W,
    parameter int PA_W     = PPN_W + nbr_xlat_pkg::OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [1:0]       rsp_kind,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    input  logic             walk_rsp_valid,
    input  logic [PPN_W-1:0] walk_rsp_ppn,
    output logic             verify_valid,
    output logic [VPN_W-1:0] verify_vpn,
    output logic [PPN_W-1:0] verify_ppn
);
    import nbr_xlat_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

    logic             busy_q;
    logic [VPN_W-1:0] pend_vpn_q;
    logic             rsp_valid_q;
    rsp_kind_e        rsp_kind_q;
    logic [PA_W-1:0]  rsp_paddr_q;
    logic             walk_valid_q;
    logic             verify_valid_q;
    logic [VPN_W-1:0] verify_vpn_q;
    logic [PPN_W-1:0] verify_ppn_q;

    logic [VPN_W-1:0] req_vpn;
    logic [OFS_W-1:0] req_ofs;
    logic             accept;
    logic             fill;
    logic             exact_hit;
    logic [IDX_W-1:0] exact_idx;
    logic [PPN_W-1:0] exact_ppn;
    logic             nbr_hit;
    logic [PPN_W-1:0] spec_ppn;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;
    logic [IDX_W-1:0] victim_idx;

    assign req_vpn   = req_vaddr[VA_W-1:OFS_W];
    assign req_ofs   = req_vaddr[OFS_W-1:0];
    assign accept    = req_valid && !busy_q;
    assign fill      = walk_rsp_valid && busy_q;
    assign touch     = fill || (accept && exact_hit);
    assign touch_idx = fill ? victim_idx : exact_idx;

    nbr_lookup #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .NBR_BITS(NBR_BITS), .IDX_W(IDX_W)
    ) u_lookup (
        .req_vpn  (req_vpn),
        .valid_vec(valid_q),
        .tags     (tag_q),
        .ppns     (ppn_q),
        .exact_hit(exact_hit),
        .exact_idx(exact_idx),
        .exact_ppn(exact_ppn),
        .nbr_hit  (nbr_hit),
        .spec_ppn (spec_ppn)
    );

    nbr_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .valid_vec (valid_q),
        .victim_idx(victim_idx)
    );

    // Response register: kind and address one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_kind_q  <= KIND_MISS;
            rsp_paddr_q <= '0;
        end else begin
            rsp_valid_q <= accept;
            if (accept) begin
                if (exact_hit) begin
                    rsp_kind_q  <= KIND_HIT;
                    rsp_paddr_q <= {exact_ppn, req_ofs};
                end else if (nbr_hit) begin
                    rsp_kind_q  <= KIND_SPEC;
                    rsp_paddr_q <= {spec_ppn, req_ofs};
                end else begin
                    rsp_kind_q  <= KIND_MISS;
                    rsp_paddr_q <= '0;
                end
            end
        end
    end

    // Walk control: one outstanding walk, raised with the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            walk_valid_q <= 1'b0;
            pend_vpn_q   <= '0;
        end else begin
            walk_valid_q <= accept && !exact_hit;
            if (accept && !exact_hit) begin
                busy_q     <= 1'b1;
                pend_vpn_q <= req_vpn;
            end else if (fill) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Table storage: install the walked translation into the victim slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill) begin
            valid_q[victim_idx] <= 1'b1;
            tag_q[victim_idx]   <= pend_vpn_q;
            ppn_q[victim_idx]   <= walk_rsp_ppn;
        end
    end

    // Verify broadcast: one pulse after each fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verify_valid_q <= 1'b0;
            verify_vpn_q   <= '0;
            verify_ppn_q   <= '0;
        end else begin
            verify_valid_q <= fill;
            if (fill) begin
                verify_vpn_q <= pend_vpn_q;
                verify_ppn_q <= walk_rsp_ppn;
            end
        end
    end

    assign req_ready      = !busy_q;
    assign rsp_valid      = rsp_valid_q;
    assign rsp_kind       = rsp_kind_q;
    assign rsp_paddr      = rsp_paddr_q;
    assign walk_req_valid = walk_valid_q;
    assign walk_req_vpn   = pend_vpn_q;
    assign verify_valid   = verify_valid_q;
    assign verify_vpn     = verify_vpn_q;
    assign verify_ppn     = verify_ppn_q;
endmodule

// File: rtl/nbr_xlat_chk.sv
// Port-level protocol checker for nbr_xlat_buf, attached with bind.
// Assumes the walker answers only while req_ready is low.
module nbr_xlat_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 24,
    parameter int VA_W  = VPN_W + 12,
    parameter int PA_W  = PPN_W + 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             rsp_valid,
    input logic [1:0]       rsp_kind,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             walk_req_valid,
    input logic [VPN_W-1:0] walk_req_vpn,
    input logic             walk_rsp_valid,
    input logic [PPN_W-1:0] walk_rsp_ppn,
    input logic             verify_valid,
    input logic [VPN_W-1:0] verify_vpn,
    input logic [PPN_W-1:0] verify_ppn
);
    // R8
    rsp_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready));

    // R6
    miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b00) |-> (rsp_paddr == '0));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 2'b00) |-> (rsp_paddr[11:0] == $past(req_vaddr[11:0])));

    // R7
    walk_with_nonhit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != 2'b01) |-> walk_req_valid);

    // R7
    walk_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> (rsp_valid && rsp_kind != 2'b01 &&
                            walk_req_vpn == $past(req_vaddr[VA_W-1:12])));

    // R8
    busy_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready);

    // R9
    verify_follows_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_valid |-> ($past(walk_rsp_valid) && verify_ppn == $past(walk_rsp_ppn) && req_ready));

    // R9
    verify_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verify_valid |=> !verify_valid);

    // R2
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_kind != 2'b11));
endmodule

bind nbr_xlat_buf nbr_xlat_chk #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .VA_W(VA_W), .PA_W(PA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_paddr(rsp_paddr), .walk_req_valid(walk_req_valid),
    .walk_req_vpn(walk_req_vpn), .walk_rsp_valid(walk_rsp_valid),
    .walk_rsp_ppn(walk_rsp_ppn), .verify_valid(verify_valid),
    .verify_vpn(verify_vpn), .verify_ppn(verify_ppn)
);

// File: tb/tb_nbr_xlat_buf.sv
// Self-checking bench: a vector table of requests and walk answers,
// then directed reset checks.
module tb_nbr_xlat_buf;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES  = 4;
    localparam int VPN_W    = 20;
    localparam int PPN_W    = 24;
    localparam int NBR_BITS = 12;
    localparam int VA_W     = VPN_W + 12;
    localparam int PA_W     = PPN_W + 12;
    localparam int NVEC     = 12;

    localparam logic [1:0] K_MISS = 2'b00;
    localparam logic [1:0] K_HIT  = 2'b01;
    localparam logic [1:0] K_SPEC = 2'b10;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [11:0]      ofs;
        logic [1:0]       kind;
        logic [PPN_W-1:0] ppn;
        logic [PPN_W-1:0] walk_ppn;
    } vec_t;

    localparam vec_t VEC [0:NVEC-1] = '{
        '{20'h00180, 12'h123, K_MISS, 24'h000000, 24'h003750},
        '{20'h00190, 12'h456, K_SPEC, 24'h003760, 24'h003760},
        '{20'h00180, 12'habc, K_HIT,  24'h003750, 24'h000000},
        '{20'h00170, 12'h010, K_SPEC, 24'h003740, 24'h009000},
        '{20'h01000, 12'hfff, K_MISS, 24'h000000, 24'h000500},
        '{20'h00190, 12'h000, K_HIT,  24'h003760, 24'h000000},
        '{20'h01005, 12'h777, K_SPEC, 24'h000505, 24'h000505},
        '{20'h00180, 12'h321, K_SPEC, 24'h003750, 24'h003750},
        '{20'h00170, 12'h654, K_SPEC, 24'h003740, 24'h009000},
        '{20'h00100, 12'h0ab, K_SPEC, 24'h0036d0, 24'h0036d0},
        '{20'h01005, 12'hcde, K_HIT,  24'h000505, 24'h000000},
        '{20'h00190, 12'h111, K_SPEC, 24'h003760, 24'h003760}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VA_W-1:0]  req_vaddr = '0;
    logic             rsp_valid;
    logic [1:0]       rsp_kind;
    logic [PA_W-1:0]  rsp_paddr;
    logic             walk_req_valid;
    logic [VPN_W-1:0] walk_req_vpn;
    logic             walk_rsp_valid = 1'b0;
    logic [PPN_W-1:0] walk_rsp_ppn = '0;
    logic             verify_valid;
    logic [VPN_W-1:0] verify_vpn;
    logic [PPN_W-1:0] verify_ppn;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nbr_xlat_buf #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .NBR_BITS(NBR_BITS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_paddr(rsp_paddr), .walk_req_valid(walk_req_valid),
        .walk_req_vpn(walk_req_vpn), .walk_rsp_valid(walk_rsp_valid),
        .walk_rsp_ppn(walk_rsp_ppn), .verify_valid(verify_valid),
        .verify_vpn(verify_vpn), .verify_ppn(verify_ppn)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0, 4:   return "R6";
            1, 3:   return "R4";
            2, 5:   return "R2";
            6:      return "R3";
            7, 8:   return "R10";
            9, 10:  return "R11";
            default: return "R5";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One request plus, if it is not a hit, the walk and its verify
    task automatic run_req(input logic [VPN_W-1:0] vpn, input logic [11:0] ofs,
                           input logic [1:0] kind, input logic [PPN_W-1:0] ppn,
                           input logic [PPN_W-1:0] wppn, input string tag);
        logic [PA_W-1:0] exp_pa;
        exp_pa = (kind == K_MISS) ? '0 : {ppn, ofs};
        chk(req_ready == 1'b1, "R8", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = {vpn, ofs};
        step();
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, tag, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_kind == kind, tag, "rsp_kind", 64'(rsp_kind), 64'(kind));
        chk(rsp_paddr == exp_pa, tag, "rsp_paddr (R3 offset)", 64'(rsp_paddr), 64'(exp_pa));
        chk(walk_req_valid == (kind != K_HIT), "R7", "walk_req_valid",
            64'(walk_req_valid), 64'(kind != K_HIT));
        if (kind != K_HIT) begin
            chk(walk_req_vpn == vpn, "R7", "walk_req_vpn", 64'(walk_req_vpn), 64'(vpn));
            chk(req_ready == 1'b0, "R8", "ready low during walk", 64'(req_ready), 64'd0);
            req_valid = 1'b1;
            req_vaddr = {vpn ^ 20'h00001, ofs};
            for (int k = 0; k < 3; k++) begin
                step();
                chk(!rsp_valid && !walk_req_valid, "R8", "ignored request",
                    64'({rsp_valid, walk_req_valid}), 64'd0);
            end
            req_valid = 1'b0;
            walk_rsp_valid = 1'b1;
            walk_rsp_ppn = wppn;
            step();
            walk_rsp_valid = 1'b0;
            chk(verify_valid == 1'b1, "R9", "verify_valid", 64'(verify_valid), 64'd1);
            chk(verify_vpn == vpn, "R9", "verify_vpn", 64'(verify_vpn), 64'(vpn));
            chk(verify_ppn == wppn, "R9", "verify_ppn", 64'(verify_ppn), 64'(wppn));
            chk(req_ready == 1'b1, "R9", "ready after verify", 64'(req_ready), 64'd1);
            step();
            chk(verify_valid == 1'b0, "R9", "verify one cycle", 64'(verify_valid), 64'd0);
        end else begin
            step();
            chk(rsp_valid == 1'b0, "R2", "response one cycle", 64'(rsp_valid), 64'd0);
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk({rsp_valid, walk_req_valid, verify_valid} == 3'b000, "R1", "strobes",
            64'({rsp_valid, walk_req_valid, verify_valid}), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_req(VEC[i].vpn, VEC[i].ofs, VEC[i].kind, VEC[i].ppn,
                    VEC[i].walk_ppn, vec_tag(i));
        end

        // R1: reset empties the table, so a former hit becomes a miss
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk(req_ready == 1'b1, "R1", "ready after second reset", 64'(req_ready), 64'd1);
        run_req(20'h01005, 12'h5a5, K_MISS, 24'h0, 24'h000777, "R1");
        // R2: the freshly walked page now hits
        run_req(20'h01005, 12'h0f0, K_HIT, 24'h000777, 24'h0, "R2");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule